// File: doc/BRIEF.md
# Six-Channel Fan Controller Register Bank

This block is the register side of a six-channel fan controller as seen by a host on a byte-oriented serial bus. The bus front end, which is not part of this block, turns bus activity into single-cycle strobes. There is a strobe for the start of a write transfer and one for the start of a read transfer. A write-byte strobe carries a data byte. A read-byte request asks for one byte. The block answers every written byte with an acknowledge or a refusal one cycle later, and it returns every requested byte one cycle later.

Each channel holds a fan configuration byte, a fan dynamics byte, a 16-bit PWM target duty word and a 16-bit tach target word. Twelve 16-bit tach count words are not written by the host. The block computes them from the PWM value instead, using a simple linear fan model. Fault status always reads as clear. A transfer names a register with a pointer byte, and the data bytes that follow all act on that same register. A single data byte updates one half of a 16-bit word. A pair of data bytes replaces the whole word. A one-cycle error flag marks any data byte or read byte that falls on an address where no register exists.

Top module: `fanctl_regbank`

## Requirements
- R1: After reset, every configuration byte reads 0x00, every dynamics byte reads 0x4C, every tach target reads 0x3C00, every PWM target reads 0x0000 and all twelve tach counts read 0x4440.
- R2: The first byte written after a write start sets the register pointer and is acknowledged (rsp_valid=1, rsp_nak=0). Later bytes never advance the pointer, so a two-byte write to 0x42 leaves 0x44 unchanged.
- R3: The second written byte is a one-byte write. At an even (MSB) address of a 16-bit word it replaces bits 15:8 and keeps bits 7:0. At an odd (LSB) address it replaces bits 7:0 and keeps bits 15:8.
- R4: The third written byte completes a two-byte write at the even address of a PWM target (0x40+2n) or tach target (0x50+2n) word. The word becomes {second byte, third byte}.
- R5: A fourth or later byte in one write transfer gets rsp_nak=1, changes no register and raises no error flag.
- R6: A read at an even address of a 16-bit word returns bits 15:8 and then bits 7:0. A read at an odd address returns bits 7:0 and then 0x00. A read of a configuration or dynamics byte returns the byte and then 0x00.
- R7: The read byte index wraps to the first byte after two reads, and a read start resets it. Any read byte clears the write byte count, so the next written byte is taken as a pointer.
- R8: The PWM duty addresses 0x30..0x3B read the same words as the PWM target addresses 0x40..0x4B. Writes to duty addresses and to tach count addresses 0x18..0x2F change nothing.
- R9: The fault status addresses 0x10 and 0x11 always read 0x00.
- R10: Every write to a PWM target word n sets tach count n to (0x1000 + ((pwm >> 7) << 3)) with bits 4:0 cleared. No other tach count changes.
- R11: Configuration (0x02..0x07) and dynamics (0x08..0x0D) bytes take only the second written byte. The third byte of a transfer to them is ignored.
- R12: A data byte or a read byte at an address with no register reads 0x00, changes nothing and pulses bad_addr for one cycle. A pointer byte never raises bad_addr.
- R13: rsp_valid follows each written byte by exactly one cycle, and rd_valid with rd_data follows each read request by exactly one cycle. If wr_valid and rd_req arrive together, the write wins and the read is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_start | input | 1 | Start-of-write event strobe |
| rd_start | input | 1 | Start-of-read event strobe |
| wr_valid | input | 1 | Written byte strobe |
| wr_data | input | 8 | Written byte |
| rd_req | input | 1 | Read byte request |
| rsp_valid | output | 1 | Response to a written byte |
| rsp_nak | output | 1 | Written byte refused |
| rd_valid | output | 1 | Read byte valid |
| rd_data | output | 8 | Read byte |
| bad_addr | output | 1 | Access to an unmapped address, one-cycle pulse |

## Verification
The bench targets half-word merging at both the even and the odd address. A design that swapped or cleared the kept half would return a corrupted word on read-back. It drives four-byte transfers: a design that let the fourth byte through would overwrite the word or acknowledge it. It reads three bytes in a row and restarts reads mid-pair, which exposes a read index that does not wrap or that survives a read start. It also writes a byte straight after a read with no write start. A design that kept the old byte count would treat that byte as data rather than as a pointer. Finally, it checks that tach counts follow PWM writes channel by channel, and that writes to read-only and unmapped addresses leave every register intact.

// File: rtl/fanctl_pkg.sv
package fanctl_pkg;
  typedef enum logic [2:0] {
    RK_NONE, RK_CFG, RK_DYN, RK_FAULT, RK_TACH, RK_DUTY, RK_TGT, RK_TTGT
  } reg_kind_e;

  localparam logic [7:0] A_CFG   = 8'h02;
  localparam logic [7:0] A_DYN   = 8'h08;
  localparam logic [7:0] A_FAULT = 8'h10;
  localparam logic [7:0] A_TACH  = 8'h18;
  localparam logic [7:0] A_DUTY  = 8'h30;
  localparam logic [7:0] A_TGT   = 8'h40;
  localparam logic [7:0] A_TTGT  = 8'h50;
endpackage

// File: rtl/fanctl_decode.sv
module fanctl_decode
  import fanctl_pkg::*;
#(
  parameter int NCH = 6,
  parameter int BW  = 8,
  parameter int IW  = 4
) (
  input  logic [BW-1:0] ptr,
  output reg_kind_e     kind,
  output logic [IW-1:0] idx,
  output logic          lo
);
  localparam int NTACH = 2 * NCH;
  localparam logic [BW-1:0] CFG_END  = BW'(int'(A_CFG) + NCH);
  localparam logic [BW-1:0] DYN_END  = BW'(int'(A_DYN) + NCH);
  localparam logic [BW-1:0] TACH_END = BW'(int'(A_TACH) + 2 * NTACH);
  localparam logic [BW-1:0] DUTY_END = BW'(int'(A_DUTY) + 2 * NCH);
  localparam logic [BW-1:0] TGT_END  = BW'(int'(A_TGT) + 2 * NCH);
  localparam logic [BW-1:0] TTGT_END = BW'(int'(A_TTGT) + 2 * NCH);

  logic [BW-1:0] off;

  always_comb begin
    kind = RK_NONE;
    idx  = '0;
    lo   = 1'b0;
    off  = '0;
    if (ptr >= A_CFG && ptr < CFG_END) begin
      kind = RK_CFG;
      off  = ptr - A_CFG;
      idx  = off[IW-1:0];
    end else if (ptr >= A_DYN && ptr < DYN_END) begin
      kind = RK_DYN;
      off  = ptr - A_DYN;
      idx  = off[IW-1:0];
    end else if (ptr == A_FAULT || ptr == A_FAULT + 1'b1) begin
      kind = RK_FAULT;
    end else if (ptr >= A_TACH && ptr < TACH_END) begin
      kind = RK_TACH;
      off  = ptr - A_TACH;
      idx  = off[IW:1];
      lo   = off[0];
    end else if (ptr >= A_DUTY && ptr < DUTY_END) begin
      kind = RK_DUTY;
      off  = ptr - A_DUTY;
      idx  = off[IW:1];
      lo   = off[0];
    end else if (ptr >= A_TGT && ptr < TGT_END) begin
      kind = RK_TGT;
      off  = ptr - A_TGT;
      idx  = off[IW:1];
      lo   = off[0];
    end else if (ptr >= A_TTGT && ptr < TTGT_END) begin
      kind = RK_TTGT;
      off  = ptr - A_TTGT;
      idx  = off[IW:1];
      lo   = off[0];
    end
  end
endmodule

// File: rtl/fanctl_tach_model.sv
module fanctl_tach_model #(
  parameter int          DW       = 16,
  parameter int          SHR      = 7,
  parameter int          SHL      = 3,
  parameter int          LOW_BITS = 5,
  parameter logic [15:0] BASE     = 16'h1000
) (
  input  logic [DW-1:0] pwm,
  output logic [DW-1:0] count
);
  localparam logic [DW-1:0] LOW_MASK = DW'((1 << LOW_BITS) - 1);

  logic [DW-1:0] scaled;
  logic [DW-1:0] raw;

  assign scaled = (pwm >> SHR) << SHL;
  assign raw    = DW'(BASE) + scaled;
  assign count  = raw & ~LOW_MASK;
endmodule

// File: rtl/fanctl_xfer_seq.sv
module fanctl_xfer_seq #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_start,
  input  logic          rd_start,
  input  logic          wr_valid,
  input  logic [BW-1:0] wr_data,
  input  logic          rd_req,
  output logic [BW-1:0] ptr,
  output logic [BW-1:0] held_byte,
  output logic          do_wr1,
  output logic          do_wr2,
  output logic          do_nak,
  output logic          do_rd,
  output logic          rd_second
);
  localparam logic [1:0] CNT_PTR  = 2'd0;
  localparam logic [1:0] CNT_ONE  = 2'd1;
  localparam logic [1:0] CNT_TWO  = 2'd2;
  localparam logic [1:0] CNT_FULL = 2'd3;

  logic [1:0] wcnt;
  logic [1:0] wcnt_eff;
  logic       ridx;

  always_comb begin
    wcnt_eff  = wr_start ? CNT_PTR : wcnt;
    do_wr1    = wr_valid && (wcnt_eff == CNT_ONE);
    do_wr2    = wr_valid && (wcnt_eff == CNT_TWO);
    do_nak    = wr_valid && (wcnt_eff == CNT_FULL);
    do_rd     = rd_req && !wr_valid;
    rd_second = rd_start ? 1'b0 : ridx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr       <= '0;
      held_byte <= '0;
      wcnt      <= CNT_PTR;
      ridx      <= 1'b0;
    end else begin
      if (wr_valid) begin
        if (wcnt_eff == CNT_PTR) ptr <= wr_data;
        if (wcnt_eff == CNT_ONE) held_byte <= wr_data;
        if (wcnt_eff != CNT_FULL) wcnt <= wcnt_eff + 2'd1;
        else wcnt <= CNT_FULL;
      end else if (do_rd || wr_start) begin
        wcnt <= CNT_PTR;
      end
      if (do_rd) ridx <= ~rd_second;
      else if (rd_start) ridx <= 1'b0;
    end
  end
endmodule

// File: rtl/fanctl_regbank.sv
module fanctl_regbank
  import fanctl_pkg::*;
#(
  parameter int          NCH      = 6,
  parameter int          BW       = 8,
  parameter logic [7:0]  CFG_RST  = 8'h00,
  parameter logic [7:0]  DYN_RST  = 8'h4C,
  parameter logic [15:0] TTGT_RST = 16'h3C00,
  parameter logic [15:0] CNT_RST  = 16'h4444,
  parameter int          LOW_BITS = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_start,
  input  logic          rd_start,
  input  logic          wr_valid,
  input  logic [BW-1:0] wr_data,
  input  logic          rd_req,
  output logic          rsp_valid,
  output logic          rsp_nak,
  output logic          rd_valid,
  output logic [BW-1:0] rd_data,
  output logic          bad_addr
);
  localparam int DW    = 2 * BW;
  localparam int NTACH = 2 * NCH;
  localparam int IW    = $clog2(NTACH);
  localparam int CW    = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [DW-1:0] CNT_INIT = DW'(CNT_RST) & ~DW'((1 << LOW_BITS) - 1);

  logic [BW-1:0] cfg_q  [NCH];
  logic [BW-1:0] dyn_q  [NCH];
  logic [DW-1:0] pwm_q  [NCH];
  logic [DW-1:0] ttg_q  [NCH];
  logic [DW-1:0] cnt_q  [NTACH];

  logic [BW-1:0] ptr, held_byte;
  logic          do_wr1, do_wr2, do_nak, do_rd, rd_second;
  reg_kind_e     kind;
  logic [IW-1:0] idx;
  logic [CW-1:0] chi;
  logic          lo;

  fanctl_xfer_seq #(.BW(BW)) u_seq (
    .clk(clk), .rst(rst), .wr_start(wr_start), .rd_start(rd_start),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req),
    .ptr(ptr), .held_byte(held_byte), .do_wr1(do_wr1), .do_wr2(do_wr2),
    .do_nak(do_nak), .do_rd(do_rd), .rd_second(rd_second)
  );

  fanctl_decode #(.NCH(NCH), .BW(BW), .IW(IW)) u_dec (
    .ptr(ptr), .kind(kind), .idx(idx), .lo(lo)
  );

  assign chi = idx[CW-1:0];

  // Word writes: one byte merges into a half, a byte pair replaces all.
  logic          pwm_we, ttg_we;
  logic [DW-1:0] pwm_new, ttg_new, cnt_new;

  function automatic logic [DW-1:0] merge_half(
    input logic [DW-1:0] old, input logic [BW-1:0] b, input logic low_half);
    return low_half ? {old[DW-1:BW], b} : {b, old[BW-1:0]};
  endfunction

  always_comb begin
    pwm_we  = (do_wr1 && kind == RK_TGT) || (do_wr2 && kind == RK_TGT && !lo);
    ttg_we  = (do_wr1 && kind == RK_TTGT) || (do_wr2 && kind == RK_TTGT && !lo);
    pwm_new = do_wr2 ? {held_byte, wr_data} : merge_half(pwm_q[chi], wr_data, lo);
    ttg_new = do_wr2 ? {held_byte, wr_data} : merge_half(ttg_q[chi], wr_data, lo);
  end

  fanctl_tach_model #(.DW(DW), .LOW_BITS(LOW_BITS)) u_tach (
    .pwm(pwm_new), .count(cnt_new)
  );

  // Read byte selection.
  logic [DW-1:0] rd_word;
  logic          rd_narrow;
  logic [BW-1:0] rd_b0, rd_b1;

  always_comb begin
    rd_word   = '0;
    rd_narrow = 1'b0;
    unique case (kind)
      RK_CFG:  begin rd_word = DW'(cfg_q[chi]); rd_narrow = 1'b1; end
      RK_DYN:  begin rd_word = DW'(dyn_q[chi]); rd_narrow = 1'b1; end
      RK_TACH: rd_word = cnt_q[idx];
      RK_DUTY, RK_TGT: rd_word = pwm_q[chi];
      RK_TTGT: rd_word = ttg_q[chi];
      default: rd_word = '0;
    endcase
    if (rd_narrow || lo) begin
      rd_b0 = rd_word[BW-1:0];
      rd_b1 = '0;
    end else begin
      rd_b0 = rd_word[DW-1:BW];
      rd_b1 = rd_word[BW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin
        cfg_q[c] <= CFG_RST;
        dyn_q[c] <= DYN_RST;
        pwm_q[c] <= '0;
        ttg_q[c] <= DW'(TTGT_RST);
      end
      for (int t = 0; t < NTACH; t++) cnt_q[t] <= CNT_INIT;
      rsp_valid <= 1'b0;
      rsp_nak   <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      bad_addr  <= 1'b0;
    end else begin
      rsp_valid <= wr_valid;
      rsp_nak   <= do_nak;
      rd_valid  <= do_rd;
      bad_addr  <= (do_wr1 || do_wr2 || do_rd) && (kind == RK_NONE);
      if (do_rd) rd_data <= rd_second ? rd_b1 : rd_b0;
      if (do_wr1 && kind == RK_CFG) cfg_q[chi] <= wr_data;
      if (do_wr1 && kind == RK_DYN) dyn_q[chi] <= wr_data;
      if (pwm_we) begin
        pwm_q[chi] <= pwm_new;
        cnt_q[idx] <= cnt_new;
      end
      if (ttg_we) ttg_q[chi] <= ttg_new;
    end
  end
endmodule

// File: rtl/fanctl_regbank_chk.sv
module fanctl_regbank_chk (
  input logic clk,
  input logic rst,
  input logic wr_start,
  input logic rd_start,
  input logic wr_valid,
  input logic rd_req,
  input logic rsp_valid,
  input logic rsp_nak,
  input logic rd_valid,
  input logic bad_addr
);
  AST_WR_RSP: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> rsp_valid); // R13
  AST_NO_IDLE_RSP: assert property (@(posedge clk) disable iff (rst)
    !wr_valid |=> !rsp_valid); // R13
  AST_RD_RSP: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !wr_valid) |=> rd_valid); // R13
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    bad_addr |-> $past(wr_valid || rd_req)); // R12
  AST_NAK_STICKY: assert property (@(posedge clk) disable iff (rst)
    (rsp_nak && wr_valid && !wr_start && !rd_start) |=> rsp_nak); // R5
  AST_NAK_QUIET: assert property (@(posedge clk) disable iff (rst)
    rsp_nak |-> (!bad_addr && !rd_valid)); // R5
  AST_NAK_IS_RSP: assert property (@(posedge clk) disable iff (rst)
    rsp_nak |-> rsp_valid); // R2
endmodule

bind fanctl_regbank fanctl_regbank_chk u_chk (
  .clk(clk), .rst(rst), .wr_start(wr_start), .rd_start(rd_start),
  .wr_valid(wr_valid), .rd_req(rd_req), .rsp_valid(rsp_valid),
  .rsp_nak(rsp_nak), .rd_valid(rd_valid), .bad_addr(bad_addr)
);

// File: tb/fanctl_regbank_test.sv
module fanctl_regbank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_start = 0, rd_start = 0, wr_valid = 0, rd_req = 0;
  logic [7:0] wr_data = 0;
  logic rsp_valid, rsp_nak, rd_valid, bad_addr;
  logic [7:0] rd_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  fanctl_regbank uut (
    .clk(clk), .rst(rst), .wr_start(wr_start), .rd_start(rd_start),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req),
    .rsp_valid(rsp_valid), .rsp_nak(rsp_nak), .rd_valid(rd_valid),
    .rd_data(rd_data), .bad_addr(bad_addr)
  );

  int vecs = 0, miss = 0;
  int m_cfg[NCH], m_dyn[NCH], m_pwm[NCH], m_ttg[NCH], m_cnt[2*NCH];
  int m_ptr = 0, m_len = 0, m_oidx = 0, m_hold = 0;
  bit e_rsp = 0, e_nak = 0, e_rdv = 0, e_bad = 0;
  int e_rd = 0;
  string e_tag = "R1";

  function automatic int tachf(int p);
    int v = 4096 + (p / 128) * 8;
    return v - (v % 32);
  endfunction

  // kind: 0 none, 1 cfg, 2 dyn, 3 fault, 4 tach, 5 duty, 6 target, 7 tach target
  function automatic void mdec(int a, output int k, output int ix, output bit lo);
    k = 0; ix = 0; lo = 0;
    if (a >= 2 && a < 2 + NCH) begin k = 1; ix = a - 2; end
    else if (a >= 8 && a < 8 + NCH) begin k = 2; ix = a - 8; end
    else if (a == 16 || a == 17) k = 3;
    else if (a >= 24 && a < 24 + 4*NCH) begin k = 4; ix = (a-24)/2; lo = a[0]; end
    else if (a >= 48 && a < 48 + 2*NCH) begin k = 5; ix = (a-48)/2; lo = a[0]; end
    else if (a >= 64 && a < 64 + 2*NCH) begin k = 6; ix = (a-64)/2; lo = a[0]; end
    else if (a >= 80 && a < 80 + 2*NCH) begin k = 7; ix = (a-80)/2; lo = a[0]; end
  endfunction

  function automatic int half(int old, int b, bit lo);
    return lo ? ((old / 256) * 256 + b) : (b * 256 + old % 256);
  endfunction

  task automatic model(bit ws, bit rs, bit wv, int wd, bit rr);
    int k, ix, w, b0, b1; bit lo;
    e_rsp = wv; e_nak = 0; e_rdv = 0; e_bad = 0;
    if (ws) m_len = 0;
    if (rs) m_oidx = 0;
    mdec(m_ptr, k, ix, lo);
    if (wv) begin
      if (m_len == 0) m_ptr = wd;
      else if (m_len == 1) begin
        m_hold = wd;
        case (k)
          0: e_bad = 1;
          1: m_cfg[ix] = wd;
          2: m_dyn[ix] = wd;
          6: begin m_pwm[ix] = half(m_pwm[ix], wd, lo); m_cnt[ix] = tachf(m_pwm[ix]); end
          7: m_ttg[ix] = half(m_ttg[ix], wd, lo);
          default: ;
        endcase
      end else if (m_len == 2) begin
        if (k == 0) e_bad = 1;
        else if (k == 6 && !lo) begin m_pwm[ix] = m_hold * 256 + wd; m_cnt[ix] = tachf(m_pwm[ix]); end
        else if (k == 7 && !lo) m_ttg[ix] = m_hold * 256 + wd;
      end else e_nak = 1;
      if (m_len < 3) m_len++;
    end else if (rr) begin
      e_rdv = 1;
      case (k)
        1: begin w = m_cfg[ix]; lo = 1; end
        2: begin w = m_dyn[ix]; lo = 1; end
        4: w = m_cnt[ix];
        5, 6: w = m_pwm[ix];
        7: w = m_ttg[ix];
        default: begin w = 0; lo = 1; end
      endcase
      if (k == 0) e_bad = 1;
      b0 = lo ? w % 256 : w / 256;
      b1 = lo ? 0 : w % 256;
      e_rd = (m_oidx == 0) ? b0 : b1;
      m_oidx = 1 - m_oidx;
      m_len = 0;
    end
  endtask

  task automatic compare();
    vecs++;
    if (rsp_valid !== e_rsp || rsp_nak !== e_nak || rd_valid !== e_rdv || bad_addr !== e_bad ||
        (e_rdv && rd_data !== 8'(e_rd))) begin
      miss++;
      $display("FAIL %s: got rsp=%b nak=%b rdv=%b rd=%h bad=%b, expected rsp=%b nak=%b rdv=%b rd=%h bad=%b",
               e_tag, rsp_valid, rsp_nak, rd_valid, rd_data, bad_addr,
               e_rsp, e_nak, e_rdv, 8'(e_rd), e_bad);
    end
  endtask

  task automatic tick(bit ws, bit rs, bit wv, int wd, bit rr, string tag);
    @(negedge clk);
    compare();
    wr_start = ws; rd_start = rs; wr_valid = wv; wr_data = 8'(wd); rd_req = rr;
    if (!rst) model(ws, rs, wv, wd, rr);
    else begin e_rsp = 0; e_nak = 0; e_rdv = 0; e_bad = 0; end
    e_tag = tag;
  endtask

  task automatic wr_bytes(int a, int n, int d0, int d1, int d2, string tag);
    tick(1, 0, 0, 0, 0, tag);
    tick(0, 0, 1, a, 0, tag);
    if (n > 0) tick(0, 0, 1, d0, 0, tag);
    if (n > 1) tick(0, 0, 1, d1, 0, tag);
    if (n > 2) tick(0, 0, 1, d2, 0, tag);
  endtask

  task automatic rd_bytes(int a, int n, string tag);
    tick(1, 0, 1, a, 0, tag);
    tick(0, 1, 0, 0, 0, tag);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 1, tag);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin
      m_cfg[c] = 0; m_dyn[c] = 'h4C; m_pwm[c] = 0; m_ttg[c] = 'h3C00;
    end
    for (int t = 0; t < 2*NCH; t++) m_cnt[t] = 'h4440;
    repeat (3) tick(0, 0, 0, 0, 0, "R1");
    rst = 1'b0;
    // R1 reset values
    for (int c = 0; c < NCH; c++) begin
      rd_bytes(2 + c, 2, "R1");
      rd_bytes(8 + c, 2, "R1");
      rd_bytes(64 + 2*c, 2, "R1");
      rd_bytes(80 + 2*c, 2, "R1");
    end
    for (int t = 0; t < 2*NCH; t++) rd_bytes(24 + 2*t, 2, "R1");
    // R3 half-word merges at even and odd addresses
    wr_bytes('h42, 1, 'hAB, 0, 0, "R3");
    rd_bytes('h42, 2, "R3");
    wr_bytes('h43, 1, 'hCD, 0, 0, "R3");
    rd_bytes('h42, 2, "R3");
    rd_bytes('h43, 2, "R6");
    wr_bytes('h53, 1, 'h77, 0, 0, "R3");
    rd_bytes('h52, 2, "R3");
    // R4 two-byte writes; R2 pointer stays put
    wr_bytes('h5A, 2, 'h12, 'h34, 0, "R4");
    rd_bytes('h5A, 2, "R4");
    wr_bytes('h44, 2, 'h81, 'h02, 0, "R4");
    rd_bytes('h46, 2, "R2");
    rd_bytes('h44, 2, "R4");
    // R5 fourth byte refused
    wr_bytes('h40, 3, 'h11, 'h22, 'h33, "R5");
    tick(0, 0, 1, 'h44, 0, "R5");
    rd_bytes('h40, 2, "R5");
    // R11 configuration and dynamics take only the first data byte
    wr_bytes('h03, 2, 'h55, 'h66, 0, "R11");
    rd_bytes('h03, 2, "R11");
    wr_bytes('h0D, 2, 'h9A, 'hBC, 0, "R11");
    rd_bytes('h0D, 2, "R11");
    // R12 unmapped addresses
    wr_bytes('h00, 2, 'hFF, 'hEE, 0, "R12");
    rd_bytes('h3C, 2, "R12");
    rd_bytes('h5C, 1, "R12");
    // R9 fault status, R8 duty mirror and read-only words
    rd_bytes('h10, 2, "R9");
    rd_bytes('h11, 2, "R9");
    rd_bytes('h32, 2, "R8");
    wr_bytes('h30, 2, 'h12, 'h34, 0, "R8");
    wr_bytes('h18, 2, 'h12, 'h34, 0, "R8");
    rd_bytes('h30, 2, "R8");
    rd_bytes('h18, 2, "R8");
    // R7 wrap, restart and write count cleared by a read
    rd_bytes('h40, 3, "R7");
    tick(0, 1, 0, 0, 0, "R7");
    tick(0, 0, 0, 0, 1, "R7");
    tick(0, 0, 0, 0, 1, "R7");
    tick(0, 0, 0, 0, 1, "R7");
    tick(0, 1, 0, 0, 0, "R7");
    tick(0, 0, 0, 0, 1, "R7");
    tick(0, 0, 1, 'h44, 0, "R7");
    tick(0, 0, 1, 'h5E, 0, "R7");
    tick(0, 1, 0, 0, 0, "R7");
    tick(0, 0, 0, 0, 1, "R7");
    // R13 collision: write wins
    tick(0, 0, 1, 'h01, 1, "R13");
    // R10 tach counts follow PWM on every channel
    for (int c = 0; c < NCH; c++) begin
      wr_bytes('h40 + 2*c, 2, (c * 'h2B + 7) % 256, (c * 'h51) % 256, 0, "R10");
      for (int t = 0; t < 2*NCH; t++) rd_bytes(24 + 2*t, 2, "R10");
    end
    wr_bytes('h4B, 1, 'hFF, 0, 0, "R10");
    rd_bytes('h22, 2, "R10");
    rd_bytes('h23, 2, "R6");
    tick(0, 0, 0, 0, 0, "R13");
    tick(0, 0, 0, 0, 0, "R13");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    miss++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule